// File: doc/BRIEF.md
# Keyboard Scan-Code Port with Acknowledge

This block sits between a keyboard and a processor bus. The keyboard offers one byte at a time on a valid/ready handshake. When the block takes a byte, it stores it in a holding register and raises an interrupt request. It then keeps the keyboard waiting until software has read the byte and acknowledged it. The byte carries a 7-bit key scan code in bits 6:0 and a release flag in bit 7: 0 means the key was pressed and 1 means it was released.

Software sees four byte registers at consecutive addresses starting at `BASE_ADDR`:

| Offset | Register | Access |
|---|---|---|
| 0 | Held scan code | read-only |
| 1 | Output latch, driven onto `pb_out` | read/write |
| 2 | Synchronized status inputs | read-only |
| 3 | Command byte | read/write, stored only |

Software acknowledges a code by writing the output latch with bit 7 set and then writing it again with bit 7 cleared. The falling edge of that bit frees the holding register, drops the interrupt request and lets the keyboard send again. Port directions are fixed, so the command byte changes nothing.

Top module: `kbd_scan_port`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `kb_ready` is 1, `kb_irq` is 0, `pb_out` is 0, and reads of offsets 0 and 3 return 0.
- R2: The block decodes only `BASE_ADDR`+0 to `BASE_ADDR`+3. A read of any other address returns 0, and a write to any other address changes no register.
- R3: When `kb_valid` and `kb_ready` are both 1 at a clock edge, the block stores `kb_code` unchanged (bits 6:0 scan code, bit 7 release flag). From the next cycle, a read of offset 0 returns that byte.
- R4: `kb_ready` is 0 from the edge that stores a code until the acknowledge completes. While it is 0, `kb_valid` is ignored and offset 0 keeps the stored byte.
- R5: `kb_irq` rises at the edge that stores a code. It stays 1 until the acknowledge completes and falls at that same edge, when `kb_ready` returns to 1.
- R6: The acknowledge completes only at the edge of a write to offset 1 that changes `pb_out[7]` from 1 to 0 while a code is held. Setting bit 7, or writing 0 to it when it is already 0, releases nothing.
- R7: A write to offset 1 loads all 8 bits of `pb_out` at that edge. A read of offset 1 returns the latch.
- R8: A write to offset 3 stores the byte, and a read of offset 3 returns it. It changes neither `pb_out`, `kb_ready`, `kb_irq` nor the other offsets.
- R9: A read of offset 2 returns `stat_in` as sampled `SYNC_STAGES` clock edges earlier (default 2). Writes to offsets 0 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kb_valid | input | 1 | Keyboard offers a code |
| kb_code | input | DATA_W | Offered code: bits 6:0 scan code, bit 7 release flag |
| kb_ready | output | 1 | Block can accept a code |
| kb_irq | output | 1 | Keyboard interrupt request |
| cpu_addr | input | ADDR_W | Bus address |
| cpu_wr | input | 1 | Write strobe for one cycle |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Combinational read data for `cpu_addr` |
| stat_in | input | DATA_W | Asynchronous status inputs shown at offset 2 |
| pb_out | output | DATA_W | Output latch; bit 7 is the acknowledge line |

## Verification
Timing:
- Storing a code, loading the output latch and completing an acknowledge each take effect at the clock edge that samples the stimulus, so `kb_ready`, `kb_irq`, `pb_out` and the read data change one edge later.
- Reads are combinational and are valid in the same cycle as the address.
- The status path lags by exactly `SYNC_STAGES` edges.

Sampling:
- The bench drives every input at the falling clock edge and samples outputs at the next falling edge, or one settle delay after setting the address for a read. Each check therefore falls on the cycle in which its result is due.
- For the status inputs the bench checks one edge too early as well as on the due edge, so both an extra stage and a missing stage are caught.

// File: rtl/kbp_pkg.sv
// Package: shared register offsets and bit positions for the keyboard scan-code port.
// Assumes byte-wide registers at four consecutive addresses.
package kbp_pkg;
    typedef enum logic [1:0] {
        OFS_SCAN = 2'd0,
        OFS_OUT  = 2'd1,
        OFS_STAT = 2'd2,
        OFS_CMD  = 2'd3
    } kbp_ofs_e;

    localparam int NUM_REGS = 4;
    localparam int ACK_BIT  = 7;
endpackage

// File: rtl/kbp_decode.sv
// Address decoder: matches the bus address against a window of four registers
// and produces the register offset plus one-hot write strobes.
// Assumes BASE_ADDR is aligned to a multiple of four.
module kbp_decode
    import kbp_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic                hit,
    output kbp_ofs_e            ofs,
    output logic [NUM_REGS-1:0] we
);
    localparam int OFS_W = $clog2(NUM_REGS);

    // Window match on the upper address bits.
    always_comb begin
        hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
        ofs = kbp_ofs_e'(addr[OFS_W-1:0]);
    end

    // One write strobe per register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
        assign we[i] = wr && hit && (addr[OFS_W-1:0] == OFS_W'(i));
    end
endmodule

// File: rtl/kbp_capture.sv
// Code holding register: accepts one keyboard code on a valid/ready handshake
// and keeps it until the acknowledge pulse frees the register.
// Assumes ack_done is only asserted while a code is held.
module kbp_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_code,
    input  logic              ack_done,
    output logic              kb_ready,
    output logic              cap_pulse,
    output logic [DATA_W-1:0] code_q
);
    logic busy_q;

    assign kb_ready  = !busy_q;
    assign cap_pulse = kb_valid && !busy_q;

    // Holding flag: set when a code is taken, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= 1'b0;
        else if (cap_pulse)  busy_q <= 1'b1;
        else if (ack_done)   busy_q <= 1'b0;
    end

    // Code register: loads only on an accepted handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)          code_q <= '0;
        else if (cap_pulse)  code_q <= kb_code;
    end
endmodule

// File: rtl/kbp_outlatch.sv
// Output latch and command byte; detects the acknowledge as a 1-to-0 write of
// the acknowledge bit while a code is held.
// Assumes one write strobe per cycle at most.
module kbp_outlatch
    import kbp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_out,
    input  logic              we_cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              holding,
    output logic [DATA_W-1:0] pb_q,
    output logic [DATA_W-1:0] cmd_q,
    output logic              ack_done
);
    // A falling write of the acknowledge bit while a code is held.
    assign ack_done = we_out && holding && pb_q[ACK_BIT] && !wdata[ACK_BIT];

    // Output latch: all bits written together.
    always_ff @(posedge clk) begin
        if (!rst_n)      pb_q <= '0;
        else if (we_out) pb_q <= wdata;
    end

    // Command byte: stored for read-back only.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (we_cmd) cmd_q <= wdata;
    end
endmodule

// File: rtl/kbp_irq.sv
// Interrupt request flop: set by a code capture, cleared by the acknowledge.
// Assumes capture and acknowledge never coincide.
module kbp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic irq
);
    // Request level held between capture and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (set_pulse) irq <= 1'b1;
        else if (clr_pulse) irq <= 1'b0;
    end
endmodule

// File: rtl/kbp_sync.sv
// Multi-stage synchronizer for the asynchronous status inputs.
// Assumes each bit may be sampled independently.
module kbp_sync #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One register stage of the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= (s == 0) ? din : stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/kbd_scan_port.sv
// Keyboard scan-code port: holds one keyboard code, raises an interrupt, and
// releases the keyboard when software pulses the acknowledge bit of the output latch.
// Assumes a single-cycle write strobe and a combinational read.
module kbd_scan_port
    import kbp_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h60,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_code,
    output logic              kb_ready,
    output logic              kb_irq,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [DATA_W-1:0] stat_in,
    output logic [DATA_W-1:0] pb_out
);
    logic                hit;
    kbp_ofs_e            ofs;
    logic [NUM_REGS-1:0] we;
    logic                ack_done;
    logic                cap_pulse;
    logic [DATA_W-1:0]   lat_code;
    logic [DATA_W-1:0]   cmd_q;
    logic [DATA_W-1:0]   stat_sync;

    kbp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (cpu_addr),
        .wr   (cpu_wr),
        .hit  (hit),
        .ofs  (ofs),
        .we   (we)
    );

    kbp_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .kb_valid  (kb_valid),
        .kb_code   (kb_code),
        .ack_done  (ack_done),
        .kb_ready  (kb_ready),
        .cap_pulse (cap_pulse),
        .code_q    (lat_code)
    );

    kbp_outlatch #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_out   (we[OFS_OUT]),
        .we_cmd   (we[OFS_CMD]),
        .wdata    (cpu_wdata),
        .holding  (!kb_ready),
        .pb_q     (pb_out),
        .cmd_q    (cmd_q),
        .ack_done (ack_done)
    );

    kbp_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (cap_pulse),
        .clr_pulse (ack_done),
        .irq       (kb_irq)
    );

    kbp_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (stat_in),
        .dout  (stat_sync)
    );

    // Read multiplexer: zero outside the decoded window.
    always_comb begin
        cpu_rdata = '0;
        if (hit) begin
            unique case (ofs)
                OFS_SCAN: cpu_rdata = lat_code;
                OFS_OUT:  cpu_rdata = pb_out;
                OFS_STAT: cpu_rdata = stat_sync;
                OFS_CMD:  cpu_rdata = cmd_q;
                default:  cpu_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/kbp_checker.sv
// Assertion checker for the keyboard scan-code port, bound to the top module.
module kbp_checker #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60,
    parameter int                DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              kb_valid,
    input logic [DATA_W-1:0] kb_code,
    input logic              kb_ready,
    input logic              kb_irq,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] pb_out,
    input logic [DATA_W-1:0] lat_code
);
    logic wr_out;
    logic fall_wr;
    assign wr_out  = cpu_wr && (cpu_addr == BASE_ADDR + ADDR_W'(1));
    assign fall_wr = wr_out && pb_out[7] && !cpu_wdata[7];

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && kb_ready) |=> (!kb_ready && lat_code == $past(kb_code)));

    assert_hold_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_ready |=> $stable(lat_code));

    assert_irq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && kb_ready) |=> kb_irq);

    assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_irq && !fall_wr) |=> kb_irq);

    assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!kb_ready && fall_wr) |=> (kb_ready && !kb_irq));

    assert_no_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!kb_ready && !fall_wr) |=> !kb_ready);

    assert_latch_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> (pb_out == $past(cpu_wdata)));
endmodule

bind kbd_scan_port kbp_checker #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_code(kb_code),
    .kb_ready(kb_ready), .kb_irq(kb_irq), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .pb_out(pb_out), .lat_code(lat_code)
);

// File: tb/sim_kbd_scan_port.sv
// Self-checking bench for the keyboard scan-code port.
module sim_kbd_scan_port;
    localparam int          AW   = 8;
    localparam logic [7:0]  BASE = 8'h60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_valid = 1'b0;
    logic [7:0] kb_code = '0;
    logic       kb_ready, kb_irq;
    logic [7:0] cpu_addr = '0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic [7:0] stat_in = '0;
    logic [7:0] pb_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state.
    logic [7:0] m_code, m_pb, m_cmd;
    bit         m_busy;

    always #10 clk = ~clk;

    kbd_scan_port #(.ADDR_W(AW), .BASE_ADDR(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_code(kb_code),
        .kb_ready(kb_ready), .kb_irq(kb_irq), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .stat_in(stat_in), .pb_out(pb_out)
    );

    function automatic logic [7:0] exp_read(input int ofs);
        case (ofs)
            0: return m_code;
            1: return m_pb;
            3: return m_cmd;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit exp_release(input logic [7:0] old_pb, input logic [7:0] wd, input bit busy);
        return busy && old_pb[7] && !wd[7];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        cpu_addr = a;
        cpu_wr   = 1'b0;
        #1;
        d = cpu_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        if (a == BASE + 8'd1) begin
            if (exp_release(m_pb, d, m_busy)) m_busy = 1'b0;
            m_pb = d;
        end else if (a == BASE + 8'd3) begin
            m_cmd = d;
        end
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        cyc();
        cpu_wr = 1'b0;
    endtask

    task automatic offer(input logic [7:0] c);
        if (!m_busy) begin
            m_code = c;
            m_busy = 1'b1;
        end
        kb_valid = 1'b1; kb_code = c;
        cyc();
        kb_valid = 1'b0;
    endtask

    task automatic check_state(input string req);
        logic [7:0] d;
        chk({req, " ready"}, {7'd0, kb_ready}, {7'd0, !m_busy});
        chk({req, " irq"}, {7'd0, kb_irq}, {7'd0, m_busy});
        chk({req, " pb_out"}, pb_out, m_pb);
        rd(BASE, d);
        chk({req, " code"}, d, exp_read(0));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        m_code = '0; m_pb = '0; m_cmd = '0; m_busy = 1'b0;
        @(negedge clk);
        cyc(); cyc();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state.
        check_state("R1");
        rd(BASE + 8'd3, d); chk("R1 cmd", d, 8'h00);

        // R3 press code, R5 irq, R4 hold.
        offer(8'h1C);
        check_state("R3 press");
        offer(8'h55);
        check_state("R4 ignored while held");

        // R6: set only, no release; write 0 with bit already 0 also no release.
        wr(BASE + 8'd1, 8'h05);
        check_state("R6 zero write no release");
        wr(BASE + 8'd1, 8'h85);
        check_state("R6 set only");
        wr(BASE + 8'd1, 8'h85);
        check_state("R6 set again");
        wr(BASE + 8'd1, 8'h05);
        check_state("R6 ack release");
        rd(BASE + 8'd1, d); chk("R7 readback", d, 8'h05);

        // R3 release-flag code.
        offer(8'h9C);
        check_state("R3 release flag");

        // R2: outside window.
        wr(BASE + 8'd5, 8'h00);
        wr(BASE + 8'd4, 8'hAA);
        check_state("R2 outside write");
        rd(BASE + 8'd4, d); chk("R2 outside read", d, 8'h00);
        rd(BASE - 8'd1, d); chk("R2 below read", d, 8'h00);

        // R8 command byte.
        wr(BASE + 8'd3, 8'hA5);
        rd(BASE + 8'd3, d); chk("R8 cmd readback", d, 8'hA5);
        check_state("R8 no side effect");

        // R9 writes to read-only offsets ignored.
        wr(BASE + 8'd0, 8'h33);
        wr(BASE + 8'd2, 8'h77);
        check_state("R9 scan write ignored");

        // R9 status sync latency.
        stat_in = 8'h3C;
        cyc();
        rd(BASE + 8'd2, d); chk("R9 stat one edge", d, 8'h00);
        cyc();
        rd(BASE + 8'd2, d); chk("R9 stat due", d, 8'h3C);

        // Finish acknowledge of held release code.
        wr(BASE + 8'd1, 8'h80);
        wr(BASE + 8'd1, 8'h00);
        check_state("R6 ack2");

        // Random traffic.
        for (int n = 0; n < 60; n++) begin
            int k = $urandom_range(0, 5);
            logic [7:0] v = 8'($urandom);
            case (k)
                0, 1: offer(v);
                2: wr(BASE + 8'd1, {1'b1, v[6:0]});
                3: wr(BASE + 8'd1, v);
                4: wr(BASE + 8'd3, v);
                default: cyc();
            endcase
            check_state("R7 random");
            rd(BASE + 8'd1, d); chk("R7 random readback", d, exp_read(1));
            rd(BASE + 8'd3, d); chk("R8 random cmd", d, exp_read(3));
        end

        // R1 reset mid-hold.
        offer(8'h2A);
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        m_busy = 1'b0; m_pb = '0; m_cmd = '0; m_code = '0;
        check_state("R1 reset again");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule